// File: doc/BRIEF.md
# Region-Level Snoop Broadcast Filter

This block sits next to one core's region directory in a snooping multiprocessor and decides, for every local miss, whether the request has to be broadcast as a snoop to the other caches or can go straight to memory. Memory is divided into aligned, power-of-two regions (1 KB by default). Each directory entry records one region and carries a single extra flag that says the region is known not to be cached by any other core. Requests to a region with that flag set skip the broadcast.

The flag is set only after a broadcast comes back with every peer reporting that it holds nothing from the region. The filter also answers region probes from the other cores. It reports a region hit whenever the probed region has a local entry, and such a probe clears the local flag, because a peer may now be caching that region. Addresses arrive as region numbers, so the block offset and region offset are already stripped. The directory is direct-mapped on the low bits of the region number. A suppressed-broadcast counter that saturates at its maximum shows how often the filter saved a snoop.

Top module: `snoopRegionFilter`

## Requirements
- R1: After reset every directory entry is invalid, all strobes are low, the suppressed-broadcast count is zero, and any probe is answered with a region miss.
- R2: A request whose region has no entry produces broadcastReq for exactly one cycle, one clock after the request. It then allocates the entry with the non-shared flag cleared, replacing whatever the set held.
- R3: A request whose region has an entry with the non-shared flag cleared produces broadcastReq, one clock after the request.
- R4: A peer response in which all rspHitVec bits are 0 raises globalMiss one clock later and sets the non-shared flag of the pending region. A following request to that region then raises memDirect instead of broadcastReq.
- R5: A peer response with any rspHitVec bit set leaves the flag unchanged and does not raise globalMiss.
- R6: Every request answered with memDirect increments suppressCnt by one in the same cycle memDirect is high. The count stops at all ones, and it changes at no other time.
- R7: A probe raises probeRespValid one clock later, with probeRespHit equal to 1 exactly when the probed region has a valid local entry.
- R8: A probe that hits clears that entry's non-shared flag, so the next request to the region raises broadcastReq.
- R9: Each request raises exactly one of broadcastReq and memDirect, and never both at once.
- R10: When a region is allocated into a set held by another region, the old region is lost: a probe to it answers region miss, and a request to it broadcasts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local miss request strobe |
| reqRegion | input | RGN_W | Region number of the local request |
| probeValid | input | 1 | Region probe from a peer |
| probeRegion | input | RGN_W | Region number being probed |
| rspValid | input | 1 | Combined peer responses for the pending broadcast |
| rspHitVec | input | PEERS | One region-hit bit per peer |
| broadcastReq | output | 1 | Request must be snooped (one cycle) |
| memDirect | output | 1 | Request may go straight to memory (one cycle) |
| probeRespValid | output | 1 | Probe answer strobe |
| probeRespHit | output | 1 | Probe answer: region held locally |
| globalMiss | output | 1 | All peers missed the pending region (one cycle) |
| suppressCnt | output | CNT_W | Saturating count of suppressed broadcasts |

## Verification
The assertions assume that at most one of request, probe and response is valid in a cycle. They also assume that a response arrives only while a broadcast is pending, and that no new request is issued until that response has come back. The random stimulus follows these rules: it picks one operation per cycle and offers a response only when its own model has a broadcast outstanding. Otherwise it chooses between a request and a probe. Region numbers are drawn from a small pool that shares a few sets, so that conflict replacements and probe hits occur often.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef struct packed {
    logic alloc;     // write the request region into its set
    logic setNs;     // mark the pending region non-shared
    logic clearNs;   // probe clears flag on a hit
    logic latchPend; // remember the broadcast region
    logic bump;      // count a suppressed broadcast
  } sfStrobes_t;
endpackage

// File: rtl/sfDatapath.sv
module sfDatapath
  import sf_pkg::*;
#(
  parameter int RGN_W = 22,
  parameter int SETS  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RGN_W-1:0] reqRegion,
  input  logic [RGN_W-1:0] probeRegion,
  input  sfStrobes_t       st,
  output logic             reqHit,
  output logic             reqNs,
  output logic             probeHit,
  output logic [CNT_W-1:0] suppressCnt
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = RGN_W - IDX_W;

  logic [SETS-1:0]  validQ;
  logic [SETS-1:0]  nsQ;
  logic [TAG_W-1:0] tagQ [SETS];

  logic [IDX_W-1:0] reqIdx, probeIdx, pendIdx;
  logic [TAG_W-1:0] reqTag, probeTag, pendTag;
  logic             pendHit;
  logic [CNT_W-1:0] cntQ;
  logic             bumpW;

  assign reqIdx   = reqRegion[IDX_W-1:0];
  assign reqTag   = reqRegion[RGN_W-1:IDX_W];
  assign probeIdx = probeRegion[IDX_W-1:0];
  assign probeTag = probeRegion[RGN_W-1:IDX_W];
  assign bumpW    = st.bump;

  assign reqHit   = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign reqNs    = nsQ[reqIdx];
  assign probeHit = validQ[probeIdx] && (tagQ[probeIdx] == probeTag);
  assign pendHit  = validQ[pendIdx] && (tagQ[pendIdx] == pendTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendIdx <= '0;
      pendTag <= '0;
    end else if (st.latchPend) begin
      pendIdx <= reqIdx;
      pendTag <= reqTag;
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : gSet
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        nsQ[g]    <= 1'b0;
        tagQ[g]   <= '0;
      end else begin
        if (st.alloc && reqIdx == IDX_W'(g)) begin
          validQ[g] <= 1'b1;
          tagQ[g]   <= reqTag;
          nsQ[g]    <= 1'b0;
        end
        if (st.setNs && pendHit && pendIdx == IDX_W'(g))
          nsQ[g] <= 1'b1;
        if (st.clearNs && probeHit && probeIdx == IDX_W'(g))
          nsQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (st.bump && cntQ != {CNT_W{1'b1}}) cntQ <= cntQ + 1'b1;
  end
  assign suppressCnt = cntQ;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != $past(cntQ)) |-> $past(bumpW)); // R6
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntQ) == {CNT_W{1'b1}}) |-> (cntQ == {CNT_W{1'b1}})); // R6
endmodule

// File: rtl/sfControl.sv
module sfControl
  import sf_pkg::*;
#(
  parameter int PEERS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             probeValid,
  input  logic             rspValid,
  input  logic [PEERS-1:0] rspHitVec,
  input  logic             reqHit,
  input  logic             reqNs,
  input  logic             probeHit,
  output sfStrobes_t       st,
  output logic             broadcastReq,
  output logic             memDirect,
  output logic             probeRespValid,
  output logic             probeRespHit,
  output logic             globalMiss
);
  logic pendQ;
  logic goDirect, goBcast, allMiss;

  assign goDirect = reqValid && reqHit && reqNs;
  assign goBcast  = reqValid && !goDirect;
  assign allMiss  = rspValid && pendQ && (rspHitVec == '0);

  always_comb begin
    st           = '0;
    st.alloc     = reqValid && !reqHit;
    st.latchPend = goBcast;
    st.setNs     = allMiss;
    st.clearNs   = probeValid;
    st.bump      = goDirect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ          <= 1'b0;
      broadcastReq   <= 1'b0;
      memDirect      <= 1'b0;
      probeRespValid <= 1'b0;
      probeRespHit   <= 1'b0;
      globalMiss     <= 1'b0;
    end else begin
      if (goBcast) pendQ <= 1'b1;
      else if (rspValid) pendQ <= 1'b0;
      broadcastReq   <= goBcast;
      memDirect      <= goDirect;
      probeRespValid <= probeValid;
      probeRespHit   <= probeValid && probeHit;
      globalMiss     <= allMiss;
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqValid, probeValid, rspValid})); // R9
  AST_RSP_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> pendQ); // R4
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !pendQ); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(broadcastReq && memDirect)); // R9
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (broadcastReq || memDirect)); // R9
  AST_PROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> probeRespValid); // R7
  AST_GMISS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    globalMiss |-> $past(rspValid)); // R4
  AST_HIT_PEER_NO_GMISS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHitVec != '0) |=> !globalMiss); // R5
endmodule

// File: rtl/snoopRegionFilter.sv
module snoopRegionFilter
  import sf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 10,
  parameter int SETS        = 16,
  parameter int PEERS       = 3,
  parameter int CNT_W       = 16,
  localparam int RGN_W      = ADDR_W - REGION_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [RGN_W-1:0] reqRegion,
  input  logic             probeValid,
  input  logic [RGN_W-1:0] probeRegion,
  input  logic             rspValid,
  input  logic [PEERS-1:0] rspHitVec,
  output logic             broadcastReq,
  output logic             memDirect,
  output logic             probeRespValid,
  output logic             probeRespHit,
  output logic             globalMiss,
  output logic [CNT_W-1:0] suppressCnt
);
  sfStrobes_t st;
  logic reqHit, reqNs, probeHit;

  sfControl #(.PEERS(PEERS)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .probeValid(probeValid),
    .rspValid(rspValid), .rspHitVec(rspHitVec), .reqHit(reqHit),
    .reqNs(reqNs), .probeHit(probeHit), .st(st),
    .broadcastReq(broadcastReq), .memDirect(memDirect),
    .probeRespValid(probeRespValid), .probeRespHit(probeRespHit),
    .globalMiss(globalMiss)
  );

  sfDatapath #(.RGN_W(RGN_W), .SETS(SETS), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .reqRegion(reqRegion), .probeRegion(probeRegion),
    .st(st), .reqHit(reqHit), .reqNs(reqNs), .probeHit(probeHit),
    .suppressCnt(suppressCnt)
  );
endmodule

// File: tb/test_snoopRegionFilter.sv
module test_snoopRegionFilter;
  localparam int RGN_W = 22;
  localparam int SETS  = 16;
  localparam int PEERS = 3;
  localparam int CNT_W = 4;
  localparam int IDX_W = 4;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, probeValid = 0, rspValid = 0;
  logic [RGN_W-1:0] reqRegion = '0, probeRegion = '0;
  logic [PEERS-1:0] rspHitVec = '0;
  logic broadcastReq, memDirect, probeRespValid, probeRespHit, globalMiss;
  logic [CNT_W-1:0] suppressCnt;

  int nTests = 0, nFail = 0;

  bit               mValid [SETS];
  bit               mNs    [SETS];
  logic [RGN_W-1:0] mRgn   [SETS];
  bit               mPend = 0;
  logic [RGN_W-1:0] mPendRgn;
  int               mCnt = 0;

  always #5 clk = ~clk;

  snoopRegionFilter #(.SETS(SETS), .PEERS(PEERS), .CNT_W(CNT_W)) i_snoopRegionFilter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRegion(reqRegion),
    .probeValid(probeValid), .probeRegion(probeRegion), .rspValid(rspValid),
    .rspHitVec(rspHitVec), .broadcastReq(broadcastReq), .memDirect(memDirect),
    .probeRespValid(probeRespValid), .probeRespHit(probeRespHit),
    .globalMiss(globalMiss), .suppressCnt(suppressCnt)
  );

  function automatic logic [RGN_W-1:0] mkRgn(int tag, int idx);
    return RGN_W'((tag << IDX_W) | idx);
  endfunction

  function automatic bit mHit(logic [RGN_W-1:0] r);
    int i = int'(r[IDX_W-1:0]);
    return mValid[i] && mRgn[i] == r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReq(logic [RGN_W-1:0] r, string req);
    bit hit = mHit(r);
    int i = int'(r[IDX_W-1:0]);
    bit expDirect = hit && mNs[i];
    @(negedge clk);
    reqValid = 1; reqRegion = r;
    @(negedge clk);
    reqValid = 0;
    chk(memDirect == expDirect, req, memDirect, expDirect);
    chk(broadcastReq == !expDirect, req, broadcastReq, !expDirect);
    if (!hit) begin mValid[i] = 1; mRgn[i] = r; mNs[i] = 0; end
    if (expDirect) begin if (mCnt < 15) mCnt++; end
    else begin mPend = 1; mPendRgn = r; end
    chk(int'(suppressCnt) == mCnt, "R6", suppressCnt, mCnt);
  endtask

  task automatic doProbe(logic [RGN_W-1:0] r, string req);
    bit hit = mHit(r);
    @(negedge clk);
    probeValid = 1; probeRegion = r;
    @(negedge clk);
    probeValid = 0;
    chk(probeRespValid == 1, "R7", probeRespValid, 1);
    chk(probeRespHit == hit, req, probeRespHit, hit);
    if (hit) mNs[int'(r[IDX_W-1:0])] = 0;
  endtask

  task automatic doRsp(logic [PEERS-1:0] v, string req);
    bit g = (v == '0);
    @(negedge clk);
    rspValid = 1; rspHitVec = v;
    @(negedge clk);
    rspValid = 0; rspHitVec = '0;
    chk(globalMiss == g, req, globalMiss, g);
    if (g && mHit(mPendRgn)) mNs[int'(mPendRgn[IDX_W-1:0])] = 1;
    mPend = 0;
  endtask

  initial begin
    #(200000 * 10);
    nTests++; nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [RGN_W-1:0] rA, rB;
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < SETS; i++) begin mValid[i] = 0; mNs[i] = 0; mRgn[i] = '0; end
    repeat (3) @(negedge clk);
    chk(broadcastReq == 0 && memDirect == 0 && globalMiss == 0 && probeRespValid == 0,
        "R1", broadcastReq | memDirect | globalMiss, 0);
    chk(suppressCnt == 0, "R1", suppressCnt, 0);
    rstN = 1;
    rA = mkRgn(5, 2);
    rB = mkRgn(9, 2);
    doProbe(rA, "R1");
    doReq(rA, "R2");                   // absent: broadcast + allocate
    doRsp(3'b000, "R4");               // all peers miss
    doReq(rA, "R4");                   // now memory direct
    doProbe(rA, "R7");                 // hit clears flag
    doReq(rA, "R8");                   // broadcast again
    doRsp(3'b010, "R5");               // a peer holds it
    doReq(rA, "R3");                   // present, not non-shared
    doRsp(3'b000, "R4");
    doReq(rB, "R10");                  // replaces rA in set 2
    doProbe(rA, "R10");
    doRsp(3'b000, "R4");
    doReq(rA, "R10");                  // lost: broadcast
    doRsp(3'b000, "R4");
    for (int k = 0; k < 20; k++) doReq(rA, "R6"); // saturate at 15
    chk(suppressCnt == 4'hF, "R6", suppressCnt, 15);
    for (int k = 0; k < 600; k++) begin
      logic [RGN_W-1:0] r = mkRgn($urandom_range(0, 3), $urandom_range(0, 3));
      if (mPend && $urandom_range(0, 1) == 0)
        doRsp(($urandom_range(0, 2) == 0) ? PEERS'($urandom_range(1, 7)) : '0, "R4");
      else if (!mPend && $urandom_range(0, 1) == 0)
        doReq(r, "R9");
      else
        doProbe(r, "R7");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule